// File: doc/BRIEF.md
# Cyclic Sense Wake Timer

This block times the sense interval while a device rests in a low-power mode. The interval is chosen by a 3-bit code together with a separate extension bit. The code is loaded through a shared timing-register write that carries a select bit. The extension bit arrives as a level from a configuration register. The interval is counted in 1 ms ticks. With the extension bit clear the interval is the code times 20 ms. With it set, the interval is eight times longer.

On entry into low-power mode the block looks at a summary of the high-side switch enables. If any switch is on, it runs in periodic mode: it emits a one-clock sense strobe each time the interval expires and starts the next interval at once. If no switch is on, it waits one interval, raises a wake request and then stops. The wake request stays high until it is cleared. Leaving low-power mode stops the timer and clears its count.

Top module: `cyclic_sense_timer`

## Requirements
- R1: After reset, senseStrobe and wakeReq are 0 and the stored interval code is 000.
- R2: A write with timWrEn=1 loads timCode into the interval code only when timSel=1. A write with timSel=0 leaves the code unchanged.
- R3: An interval code of 000 produces neither sense strobes nor a wake request in either mode, whatever the value of extBit.
- R4: With extBit=0 the interval is code×20 msTick pulses, counted from the low-power entry or from the previous expiry.
- R5: With extBit=1 the interval is code×160 msTick pulses. Code 111 gives 1120.
- R6: When switchOn=1 at entry, senseStrobe goes high for exactly one clock after the edge that takes the expiring tick, and the next interval starts from zero.
- R7: When switchOn=0 at entry, wakeReq rises once after one interval, no senseStrobe is produced, and no further expiry follows during that low-power stay.
- R8: wakeReq stays high until a clock edge with wakeClear=1 and no tick arriving, and then returns to 0.
- R9: Dropping lowPower stops the count and clears it, so a later entry counts a full interval again.
- R10: The mode is fixed at the rising edge of lowPower. A change of switchOn afterwards has no effect until the next entry.
- R11: The interval length is captured at entry. A code write during low power takes effect only at the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| timWrEn | input | 1 | Timing register write strobe |
| timSel | input | 1 | 1 = the write targets the sense interval code |
| timCode | input | 3 | Interval code written on a selected write |
| extBit | input | 1 | Interval extension (×8) from the configuration register |
| lowPower | input | 1 | High while the device is in stop or sleep mode |
| switchOn | input | 1 | High if any high-side switch is enabled |
| msTick | input | 1 | One-clock pulse every millisecond |
| wakeClear | input | 1 | Clears a pending wake request |
| senseStrobe | output | 1 | One-clock pulse at each periodic interval expiry |
| wakeReq | output | 1 | Timed wake-up request, held until cleared |

## Verification
A wrong count or a wrong captured limit shows up as a strobe or wake request on the wrong tick. It is seen on the first expiry, so at most 1120 ticks after entry. A wrong mode shows up at that same expiry: a strobe appears where a wake request belongs, or the reverse, or a second expiry follows in one-shot mode. A counter that is not cleared on exit shows up as an early expiry within the first interval after re-entry. A stuck wake request shows up in the first cycle after a clear.

// File: rtl/cst_pkg.sv
package cst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CYCLIC  = 2'd1,
    ST_ONESHOT = 2'd2,
    ST_SPENT   = 2'd3
  } cstMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero the interval counter
    logic latch;    // capture the interval length from code and extension
    logic advance;  // counter may step on a tick
  } cstCtl_t;

endpackage

// File: rtl/cst_datapath.sv
module cst_datapath
  import cst_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int STEP_MS = 20,
  parameter int EXT_MUL = 8,
  parameter int CNT_W   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timWrEn,
  input  logic              timSel,
  input  logic [CODE_W-1:0] timCode,
  input  logic              extBit,
  input  logic              msTick,
  input  cstCtl_t           ctl,
  output logic              codeZero,
  output logic              expire,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  limitVal
);

  logic [CODE_W-1:0] codeReg;
  logic [CNT_W-1:0]  baseLen;
  logic [CNT_W-1:0]  fullLen;
  logic              atLast;

  // Interval code register, written only when the sense path is selected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= '0;
    end else if (timWrEn && timSel) begin
      codeReg <= timCode;
    end
  end

  assign codeZero = (codeReg == '0);

  always_comb begin
    baseLen = CNT_W'(codeReg) * CNT_W'(STEP_MS);
    fullLen = extBit ? baseLen * CNT_W'(EXT_MUL) : baseLen;
  end

  // Interval length captured at entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitVal <= '0;
    end else if (ctl.latch) begin
      limitVal <= fullLen;
    end
  end

  assign atLast = (limitVal != '0) && (cntVal == limitVal - CNT_W'(1));
  assign expire = ctl.advance && msTick && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (ctl.clear) begin
      cntVal <= '0;
    end else if (ctl.advance && msTick) begin
      if (atLast) begin
        cntVal <= '0;
      end else begin
        cntVal <= cntVal + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cst_control.sv
module cst_control
  import cst_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lowPower,
  input  logic    switchOn,
  input  logic    wakeClear,
  input  logic    codeZero,
  input  logic    expire,
  output cstCtl_t ctl,
  output logic    senseStrobe,
  output logic    wakeReq
);

  cstMode_e mode, modeNext;
  logic     lpPrev;
  logic     entry;
  logic     running;

  assign entry   = lowPower && !lpPrev;
  assign running = (mode == ST_CYCLIC) || (mode == ST_ONESHOT);

  always_comb begin
    modeNext = mode;
    if (!lowPower) begin
      modeNext = ST_IDLE;
    end else if (entry) begin
      if (codeZero) begin
        modeNext = ST_IDLE;
      end else if (switchOn) begin
        modeNext = ST_CYCLIC;
      end else begin
        modeNext = ST_ONESHOT;
      end
    end else if (mode == ST_ONESHOT && expire) begin
      modeNext = ST_SPENT;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.clear   = entry || !lowPower;
    ctl.latch   = entry;
    ctl.advance = lowPower && !entry && running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode        <= ST_IDLE;
      lpPrev      <= 1'b0;
      senseStrobe <= 1'b0;
      wakeReq     <= 1'b0;
    end else begin
      mode        <= modeNext;
      lpPrev      <= lowPower;
      senseStrobe <= expire && (mode == ST_CYCLIC);
      if (expire && mode == ST_ONESHOT) begin
        wakeReq <= 1'b1;
      end else if (wakeClear) begin
        wakeReq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cyclic_sense_timer.sv
module cyclic_sense_timer
  import cst_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int STEP_MS = 20,
  parameter int EXT_MUL = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timWrEn,
  input  logic              timSel,
  input  logic [CODE_W-1:0] timCode,
  input  logic              extBit,
  input  logic              lowPower,
  input  logic              switchOn,
  input  logic              msTick,
  input  logic              wakeClear,
  output logic              senseStrobe,
  output logic              wakeReq
);

  localparam int MAX_LEN = ((1 << CODE_W) - 1) * STEP_MS * EXT_MUL;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  cstCtl_t          ctl;
  logic             codeZero;
  logic             expire;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] limitVal;

  cst_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lowPower   (lowPower),
    .switchOn   (switchOn),
    .wakeClear  (wakeClear),
    .codeZero   (codeZero),
    .expire     (expire),
    .ctl        (ctl),
    .senseStrobe(senseStrobe),
    .wakeReq    (wakeReq)
  );

  cst_datapath #(
    .CODE_W (CODE_W),
    .STEP_MS(STEP_MS),
    .EXT_MUL(EXT_MUL),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .timWrEn (timWrEn),
    .timSel  (timSel),
    .timCode (timCode),
    .extBit  (extBit),
    .msTick  (msTick),
    .ctl     (ctl),
    .codeZero(codeZero),
    .expire  (expire),
    .cntVal  (cntVal),
    .limitVal(limitVal)
  );

endmodule

// File: rtl/cst_checker.sv
module cst_checker #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             lowPower,
  input logic             msTick,
  input logic             wakeClear,
  input logic             senseStrobe,
  input logic             wakeReq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] limitVal
);

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    senseStrobe |=> !senseStrobe);

  p_wake_no_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReq) |-> !senseStrobe);

  p_wake_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && !wakeClear) |=> wakeReq);

  p_wake_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wakeClear && !msTick) |=> !wakeReq);

  p_exit_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !lowPower |=> (!senseStrobe && cntVal == '0));

  p_tick_paced_r4: assert property (@(posedge clk) disable iff (!rstN)
    !msTick |=> (!senseStrobe && !$rose(wakeReq)));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (limitVal != '0) |-> (cntVal < limitVal));

endmodule

bind cyclic_sense_timer cst_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lowPower   (lowPower),
  .msTick     (msTick),
  .wakeClear  (wakeClear),
  .senseStrobe(senseStrobe),
  .wakeReq    (wakeReq),
  .cntVal     (cntVal),
  .limitVal   (limitVal)
);

// File: tb/sim_cyclic_sense_timer.sv
module sim_cyclic_sense_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       timWrEn = 1'b0;
  logic       timSel = 1'b0;
  logic [2:0] timCode = 3'd0;
  logic       extBit = 1'b0;
  logic       lowPower = 1'b0;
  logic       switchOn = 1'b0;
  logic       msTick = 1'b0;
  logic       wakeClear = 1'b0;
  logic       senseStrobe;
  logic       wakeReq;

  int  errors = 0;
  int  checks = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  cyclic_sense_timer u0 (
    .clk(clk), .rstN(rstN), .timWrEn(timWrEn), .timSel(timSel),
    .timCode(timCode), .extBit(extBit), .lowPower(lowPower),
    .switchOn(switchOn), .msTick(msTick), .wakeClear(wakeClear),
    .senseStrobe(senseStrobe), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCode(input logic sel, input logic [2:0] code);
    timWrEn = 1'b1; timSel = sel; timCode = code;
    @(negedge clk);
    timWrEn = 1'b0; timSel = 1'b0;
  endtask

  task automatic enterLp(input logic sw);
    switchOn = sw;
    lowPower = 1'b1;
    @(negedge clk);
  endtask

  task automatic leaveLp();
    lowPower = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clearWake();
    wakeClear = 1'b1;
    @(negedge clk);
    wakeClear = 1'b0;
  endtask

  // n ticks; counts strobes, records first strobe tick, first wake tick,
  // and counts strobes that last longer than one clock
  task automatic runTicks(input int n, output int strobes, output int firstAt,
                          output int wakeAt, output int longPulse);
    strobes = 0; firstAt = -1; wakeAt = -1; longPulse = 0;
    for (int i = 1; i <= n; i++) begin
      msTick = 1'b1;
      @(negedge clk);
      msTick = 1'b0;
      if (senseStrobe) begin
        strobes++;
        if (firstAt < 0) firstAt = i;
      end
      if (wakeReq && wakeAt < 0) wakeAt = i;
      @(negedge clk);
      if (senseStrobe) longPulse++;
    end
  endtask

  task automatic testReset();
    int s, f, w, l;
    check("R1 strobe at reset", int'(senseStrobe), 0);
    check("R1 wake at reset", int'(wakeReq), 0);
    extBit = 1'b0;
    enterLp(1'b1);
    runTicks(100, s, f, w, l);
    check("R1 reset code 000 gives no strobe", s, 0);
    check("R1 reset code 000 gives no wake", w, -1);
    leaveLp();
  endtask

  task automatic testSelectAndCyclic();
    int s, f, w, l;
    writeCode(1'b1, 3'd1);
    writeCode(1'b0, 3'd7);
    extBit = 1'b0;
    enterLp(1'b1);
    runTicks(45, s, f, w, l);
    check("R2 unselected write ignored, first strobe", f, 20);
    check("R4 R6 periodic strobes in 45 ticks", s, 2);
    check("R6 strobe one clock wide", l, 0);
    check("R6 no wake in cyclic mode", w, -1);
    leaveLp();
  endtask

  task automatic testOneShot();
    int s, f, w, l;
    writeCode(1'b1, 3'd3);
    extBit = 1'b0;
    enterLp(1'b0);
    runTicks(200, s, f, w, l);
    check("R7 wake after 60 ticks", w, 60);
    check("R7 no strobe in one-shot mode", s, 0);
    check("R8 wake held", int'(wakeReq), 1);
    clearWake();
    check("R8 wake cleared", int'(wakeReq), 0);
    runTicks(100, s, f, w, l);
    check("R7 no second expiry", w, -1);
    leaveLp();
  endtask

  task automatic testExtended();
    int s, f, w, l;
    writeCode(1'b1, 3'd1);
    extBit = 1'b1;
    enterLp(1'b1);
    runTicks(330, s, f, w, l);
    check("R5 extended first strobe", f, 160);
    check("R5 extended strobe count", s, 2);
    leaveLp();
  endtask

  task automatic testCodeZero();
    int s, f, w, l;
    writeCode(1'b1, 3'd0);
    extBit = 1'b1;
    enterLp(1'b1);
    runTicks(1200, s, f, w, l);
    check("R3 code 000 ext 1 no strobe", s, 0);
    leaveLp();
    enterLp(1'b0);
    runTicks(200, s, f, w, l);
    check("R3 code 000 no wake", w, -1);
    leaveLp();
    extBit = 1'b0;
  endtask

  task automatic testExit();
    int s, f, w, l;
    writeCode(1'b1, 3'd1);
    extBit = 1'b0;
    enterLp(1'b1);
    runTicks(15, s, f, w, l);
    leaveLp();
    runTicks(10, s, f, w, l);
    check("R9 no strobe outside low power", s, 0);
    enterLp(1'b1);
    runTicks(15, s, f, w, l);
    check("R9 count restarted, no early strobe", s, 0);
    runTicks(5, s, f, w, l);
    check("R9 strobe after full interval", f, 5);
    leaveLp();
  endtask

  task automatic testModeLatched();
    int s, f, w, l;
    writeCode(1'b1, 3'd1);
    enterLp(1'b0);
    switchOn = 1'b1;
    runTicks(25, s, f, w, l);
    check("R10 late switch ignored, no strobe", s, 0);
    check("R10 one-shot wake kept", w, 20);
    clearWake();
    leaveLp();
  endtask

  task automatic testCodeLatched();
    int s, f, w, l;
    writeCode(1'b1, 3'd1);
    enterLp(1'b1);
    runTicks(5, s, f, w, l);
    writeCode(1'b1, 3'd2);
    runTicks(20, s, f, w, l);
    check("R11 old interval kept in low power", f, 15);
    leaveLp();
    enterLp(1'b1);
    runTicks(45, s, f, w, l);
    check("R11 new interval at next entry", f, 40);
    leaveLp();
  endtask

  task automatic testMaxInterval();
    int s, f, w, l;
    writeCode(1'b1, 3'd7);
    extBit = 1'b1;
    enterLp(1'b0);
    runTicks(1130, s, f, w, l);
    check("R5 longest interval wake", w, 1120);
    clearWake();
    leaveLp();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSelectAndCyclic();
    testOneShot();
    testExtended();
    testCodeZero();
    testExit();
    testModeLatched();
    testCodeLatched();
    testMaxInterval();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule